// File: doc/BRIEF.md
# Boot-Vector Memory Map Decoder

This block sits between an 8-bit-data processor with a 20-bit physical address bus and three memories. It has a small built-in boot ROM that holds the reset vector, an 8 KB program and stack RAM in low memory, and a 32 KB display buffer at segment A000. On every cycle it decodes the address into at most one region select. It forms an active-high write enable for each RAM from its select and the processor's active-low write strobe. It passes each RAM the low address bits that index it.

The processor reads through the block. The ROM read is registered, so it has the same one-cycle latency as the synchronous RAM arrays. The block captures the decoded region on the same clock edge as the address. On the next cycle it steers the byte of that region onto the processor's read bus. An address that hits no region reads as FFh. The ROM is computed, not stored. At offset F0h, which the processor reaches from its reset address FFFF:0000, it holds a far jump to 0000:0400. Every other ROM byte is the single-byte no-operation code 90h.

Top module: `memmap_decoder`

## Requirements
- R1: Addresses FFF00h to FFFFFh assert `rom_sel` and no other select. The ROM is indexed by address bits [7:0].
- R2: Addresses 00000h to 01FFFh assert `prog_sel` and no other select, and `prog_addr` equals address bits [12:0].
- R3: Addresses A0000h to A7FFFh assert `disp_sel` and no other select, and `disp_addr` equals address bits [14:0].
- R4: `prog_we` is 1 exactly when `prog_sel` is 1 and `cpu_wr_n` is 0. `disp_we` is 1 exactly when `disp_sel` is 1 and `cpu_wr_n` is 0. A write to the ROM region raises neither enable and changes no RAM byte.
- R5: An address outside all three regions asserts no select and no write enable, and leaves both RAMs unchanged. In the cycle after the address is presented, it reads as FFh.
- R6: ROM offsets F0h, F1h, F2h, F3h and F4h read EAh, 00h, 04h, 00h and 00h. This is a far jump with offset 0400h (low byte first), followed by segment 0000h.
- R7: Every ROM offset other than F0h to F4h reads 90h.
- R8: `cpu_rdata` in cycle t+1 shows the byte of the region decoded from the address in cycle t. For the RAMs this is the RAM's registered read data in cycle t+1. This holds when consecutive cycles address different regions.
- R9: While `rst_n` is low at a clock edge, the captured region is cleared, so `cpu_rdata` reads FFh in the following cycle whatever the address is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with processor and RAMs |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 20 | Processor physical address |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| prog_rd_data | input | 8 | Registered read data from program RAM |
| disp_rd_data | input | 8 | Registered read data from display buffer |
| rom_sel | output | 1 | Boot ROM region select |
| prog_sel | output | 1 | Program RAM region select |
| disp_sel | output | 1 | Display buffer region select |
| prog_we | output | 1 | Program RAM write enable, active high |
| disp_we | output | 1 | Display buffer write enable, active high |
| prog_addr | output | 13 | Program RAM byte index |
| disp_addr | output | 15 | Display buffer byte index |
| cpu_rdata | output | 8 | Read data to processor |

## Verification
The bench builds the block with its default map: an 8-bit ROM index at FFF00h, a 13-bit program index at 00000h and a 15-bit display index at A0000h. Region sizes this small let the bench sweep every byte of both RAMs through behavioural array models, writing a computed pattern and reading it back. It also reads every ROM offset. This covers each select boundary, the whole vector window and every aliasing bit position. Probes just outside each region, plus writes aimed at aliased addresses, show through later read-back that an unmapped or ROM access disturbs nothing.

// File: rtl/memmap_pkg.sv
// Package memmap_pkg
// Shared region encoding and byte constants for the memory map decoder.
// Assumes an 8-bit data bus.
package memmap_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_PROG = 2'd2,
        RGN_DISP = 2'd3
    } region_e;

    localparam logic [7:0] NOP_BYTE  = 8'h90;
    localparam logic [7:0] OPEN_BUS  = 8'hFF;
    localparam logic [7:0] FAR_JUMP  = 8'hEA;
endpackage

// File: rtl/region_decode.sv
// Module region_decode
// Purely combinational. It compares the upper address bits against each
// region base and produces one-hot selects, an encoded region and the write
// enables. Assumes each base is aligned to its region size and that the
// regions do not overlap.
module region_decode #(
    parameter int                ADDR_W    = 20,
    parameter int                ROM_AW    = 8,
    parameter int                PROG_AW   = 13,
    parameter int                DISP_AW   = 15,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 20'hFFF00,
    parameter logic [ADDR_W-1:0] PROG_BASE = 20'h00000,
    parameter logic [ADDR_W-1:0] DISP_BASE = 20'hA0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_n,
    output memmap_pkg::region_e region,
    output logic                rom_hit,
    output logic                prog_hit,
    output logic                disp_hit,
    output logic                prog_wen,
    output logic                disp_wen
);
    import memmap_pkg::*;

    localparam int NREG = 3;
    localparam int AW_LIST [NREG] = '{ROM_AW, PROG_AW, DISP_AW};
    localparam logic [ADDR_W-1:0] BASE_LIST [NREG] = '{ROM_BASE, PROG_BASE, DISP_BASE};

    logic [NREG-1:0] hit;

    // One comparator per region on the bits above that region's index width.
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        localparam int AW = AW_LIST[g];
        always_comb hit[g] = (addr[ADDR_W-1:AW] == BASE_LIST[g][ADDR_W-1:AW]);
    end

    assign rom_hit  = hit[0];
    assign prog_hit = hit[1];
    assign disp_hit = hit[2];

    // Encode the hit vector into the region type for the read path.
    always_comb begin
        if (hit[0])      region = RGN_ROM;
        else if (hit[1]) region = RGN_PROG;
        else if (hit[2]) region = RGN_DISP;
        else             region = RGN_NONE;
    end

    // Gate the active-low strobe with each RAM select.
    always_comb begin
        prog_wen = hit[1] & ~wr_n;
        disp_wen = hit[2] & ~wr_n;
    end
endmodule

// File: rtl/boot_rom.sv
// Module boot_rom
// Registered-read boot ROM whose contents are computed. A far jump (opcode,
// IP low/high, CS low/high) sits at VEC_OFF and every other byte is the
// no-operation code. Assumes VEC_OFF + 4 fits inside the ROM.
module boot_rom #(
    parameter int          AW      = 8,
    parameter int          VEC_OFF = 'hF0,
    parameter logic [15:0] JMP_IP  = 16'h0400,
    parameter logic [15:0] JMP_CS  = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [7:0]    data_q
);
    import memmap_pkg::*;

    localparam logic [AW-1:0] V0 = AW'(VEC_OFF);

    // Compute the content byte of one ROM offset.
    function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
        logic [AW-1:0] rel;
        rel = a - V0;
        case (rel)
            AW'(0):  rom_byte = FAR_JUMP;
            AW'(1):  rom_byte = JMP_IP[7:0];
            AW'(2):  rom_byte = JMP_IP[15:8];
            AW'(3):  rom_byte = JMP_CS[7:0];
            AW'(4):  rom_byte = JMP_CS[15:8];
            default: rom_byte = NOP_BYTE;
        endcase
    endfunction

    // Register the addressed byte, matching the latency of a synchronous RAM.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= NOP_BYTE;
        else        data_q <= rom_byte(addr);
    end
endmodule

// File: rtl/read_mux.sv
// Module read_mux
// Captures the decoded region on the same edge as the memories capture the
// address, then steers that region's byte to the processor. An empty region
// reads as open bus. Assumes every source has a one-cycle read latency.
module read_mux (
    input  logic                clk,
    input  logic                rst_n,
    input  memmap_pkg::region_e region_d,
    input  logic [7:0]          rom_q,
    input  logic [7:0]          prog_q,
    input  logic [7:0]          disp_q,
    output logic [7:0]          rdata
);
    import memmap_pkg::*;

    region_e region_q;

    // Hold the region of the address whose data returns next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) region_q <= RGN_NONE;
        else        region_q <= region_d;
    end

    // Select the returning byte by the held region.
    always_comb begin
        case (region_q)
            RGN_ROM:  rdata = rom_q;
            RGN_PROG: rdata = prog_q;
            RGN_DISP: rdata = disp_q;
            default:  rdata = OPEN_BUS;
        endcase
    end
endmodule

// File: rtl/memmap_decoder.sv
// Module memmap_decoder (top)
// Memory map for an 8-bit-data processor. It holds the boot ROM, drives the
// program RAM and display buffer selects, write enables and indexes, and
// returns read data. Assumes the external RAMs register their read data one
// cycle after the address, as the ROM here does.
module memmap_decoder #(
    parameter int                ADDR_W    = 20,
    parameter int                ROM_AW    = 8,
    parameter int                PROG_AW   = 13,
    parameter int                DISP_AW   = 15,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 20'hFFF00,
    parameter logic [ADDR_W-1:0] PROG_BASE = 20'h00000,
    parameter logic [ADDR_W-1:0] DISP_BASE = 20'hA0000,
    parameter int                VEC_OFF   = 'hF0,
    parameter logic [15:0]       JMP_IP    = 16'h0400,
    parameter logic [15:0]       JMP_CS    = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr_n,
    input  logic [7:0]         prog_rd_data,
    input  logic [7:0]         disp_rd_data,
    output logic               rom_sel,
    output logic               prog_sel,
    output logic               disp_sel,
    output logic               prog_we,
    output logic               disp_we,
    output logic [PROG_AW-1:0] prog_addr,
    output logic [DISP_AW-1:0] disp_addr,
    output logic [7:0]         cpu_rdata
);
    import memmap_pkg::*;

    region_e    region;
    logic [7:0] rom_q;

    region_decode #(
        .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .PROG_AW(PROG_AW), .DISP_AW(DISP_AW),
        .ROM_BASE(ROM_BASE), .PROG_BASE(PROG_BASE), .DISP_BASE(DISP_BASE)
    ) u_dec (
        .addr(cpu_addr), .wr_n(cpu_wr_n), .region(region),
        .rom_hit(rom_sel), .prog_hit(prog_sel), .disp_hit(disp_sel),
        .prog_wen(prog_we), .disp_wen(disp_we)
    );

    boot_rom #(
        .AW(ROM_AW), .VEC_OFF(VEC_OFF), .JMP_IP(JMP_IP), .JMP_CS(JMP_CS)
    ) u_rom (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr[ROM_AW-1:0]), .data_q(rom_q)
    );

    read_mux u_mux (
        .clk(clk), .rst_n(rst_n), .region_d(region), .rom_q(rom_q),
        .prog_q(prog_rd_data), .disp_q(disp_rd_data), .rdata(cpu_rdata)
    );

    // Pass the index bits of each RAM straight through.
    assign prog_addr = cpu_addr[PROG_AW-1:0];
    assign disp_addr = cpu_addr[DISP_AW-1:0];
endmodule

// File: rtl/memmap_decoder_chk.sv
// Module memmap_decoder_chk
// Temporal checks on the default memory map, bound to every memmap_decoder.
module memmap_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [19:0] cpu_addr,
    input logic        cpu_wr_n,
    input logic [7:0]  prog_rd_data,
    input logic [7:0]  disp_rd_data,
    input logic        rom_sel,
    input logic        prog_sel,
    input logic        disp_sel,
    input logic        prog_we,
    input logic        disp_we,
    input logic [7:0]  cpu_rdata
);
    // R1 R2 R3: never two regions at once
    a_r1_single_region: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, prog_sel, disp_sel}));

    // R2: program select only inside 00000h..01FFFh
    a_r2_prog_window: assert property (@(posedge clk) disable iff (!rst_n)
        prog_sel |-> (cpu_addr < 20'h02000));

    // R3: display select only inside A0000h..A7FFFh
    a_r3_disp_window: assert property (@(posedge clk) disable iff (!rst_n)
        disp_sel |-> (cpu_addr >= 20'hA0000 && cpu_addr <= 20'hA7FFF));

    // R4: no write enable without a low strobe
    a_r4_no_we_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_n |-> (!prog_we && !disp_we));

    // R5: unmapped address raises no write enable
    a_r5_unmapped_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel && !prog_sel && !disp_sel) |-> (!prog_we && !disp_we));

    // R5: unmapped address returns open bus next cycle
    a_r5_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rom_sel && !prog_sel && !disp_sel) |=> (cpu_rdata == 8'hFF));

    // R6: reset vector opcode returned after ROM offset F0h
    a_r6_vector_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rom_sel && cpu_addr[7:0] == 8'hF0) |=> (cpu_rdata == 8'hEA));

    // R8: program RAM data steered in the following cycle
    a_r8_prog_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && prog_sel) |=> (cpu_rdata == prog_rd_data));

    // R8: display data steered in the following cycle
    a_r8_disp_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && disp_sel) |=> (cpu_rdata == disp_rd_data));
endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
    .prog_rd_data(prog_rd_data), .disp_rd_data(disp_rd_data),
    .rom_sel(rom_sel), .prog_sel(prog_sel), .disp_sel(disp_sel),
    .prog_we(prog_we), .disp_we(disp_we), .cpu_rdata(cpu_rdata)
);

// File: tb/tb_memmap_decoder.sv
// Bench for memmap_decoder: full sweeps of both RAM windows and the ROM,
// with behavioural synchronous RAMs and arithmetic expected values.
module tb_memmap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cpu_addr = 20'h0;
    logic        cpu_wr_n = 1'b1;
    logic [7:0]  wdata = 8'h0;
    logic [7:0]  prog_rd_data, disp_rd_data;
    logic        rom_sel, prog_sel, disp_sel, prog_we, disp_we;
    logic [12:0] prog_addr;
    logic [14:0] disp_addr;
    logic [7:0]  cpu_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] pmem [8192];
    logic [7:0] dmem [32768];

    always #5 clk = ~clk;

    memmap_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
        .prog_rd_data(prog_rd_data), .disp_rd_data(disp_rd_data),
        .rom_sel(rom_sel), .prog_sel(prog_sel), .disp_sel(disp_sel),
        .prog_we(prog_we), .disp_we(disp_we), .prog_addr(prog_addr),
        .disp_addr(disp_addr), .cpu_rdata(cpu_rdata)
    );

    // Synchronous RAM models with one-cycle registered read.
    always @(posedge clk) begin
        if (prog_we) pmem[prog_addr] <= wdata;
        prog_rd_data <= pmem[prog_addr];
        if (disp_we) dmem[disp_addr] <= wdata;
        disp_rd_data <= dmem[disp_addr];
    end

    function automatic logic [7:0] pat(input int a, input int salt);
        int v;
        v = (a * 29) ^ (a >> 5) ^ salt;
        return v[7:0];
    endfunction

    function automatic logic [7:0] rom_exp(input int off);
        case (off)
            'hF0: return 8'hEA;
            'hF1: return 8'h00;
            'hF2: return 8'h04;
            'hF3: return 8'h00;
            'hF4: return 8'h00;
            default: return 8'h90;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%05h actual=%0h expected=%0h", req, cpu_addr, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // One read: present address, check decode, check data one cycle later.
    task automatic rd(input logic [19:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr_n = 1'b1;
        #1;
        if (req == "R5") check("R5 sel", {rom_sel, prog_sel, disp_sel}, 3'b000);
        @(negedge clk);
        check(req, cpu_rdata, exp);
    endtask

    // Write with the strobe low for one cycle; report the write enables seen.
    task automatic wr(input logic [19:0] a, input logic [7:0] d, output logic [1:0] wes);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr_n = 1'b0;
        wdata = d;
        #1;
        wes = {prog_we, disp_we};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [1:0] wes;
        // R9: reset clears the captured region even with a ROM address applied.
        cpu_addr = 20'hFFFF0;
        repeat (3) @(negedge clk);
        check("R9 reset read", cpu_rdata, 8'hFF);
        rst_n = 1'b1;

        // R2 R4: fill program RAM; check the index and the enables.
        for (int a = 0; a < 8192; a++) begin
            wr(20'(a), pat(a, 'h3C), wes);
            check("R4 prog write", {wes, prog_sel}, 3'b101);
            check("R2 prog index", prog_addr, a);
        end
        // R3 R4: fill the display buffer.
        for (int a = 0; a < 32768; a++) begin
            wr(20'hA0000 + 20'(a), pat(a, 'hA5), wes);
            check("R4 disp write", {wes, disp_sel}, 3'b011);
            check("R3 disp index", disp_addr, a);
        end
        // R5 R4: writes that alias RAM index 0 or hit the ROM must do nothing.
        wr(20'h02000, 8'h11, wes); check("R5 unmapped write", wes, 2'b00);
        wr(20'hA8000, 8'h22, wes); check("R5 unmapped write", wes, 2'b00);
        wr(20'h9FFFF, 8'h33, wes); check("R5 unmapped write", wes, 2'b00);
        wr(20'hFFEFF, 8'h44, wes); check("R5 unmapped write", wes, 2'b00);
        wr(20'hFFFF0, 8'h55, wes); check("R4 rom write", {wes, rom_sel}, 3'b001);
        wr(20'hFFF00, 8'h66, wes); check("R1 rom sel", {rom_sel, prog_sel, disp_sel}, 3'b100);
        @(negedge clk); cpu_wr_n = 1'b1;

        // R1 R6 R7: every ROM offset.
        for (int o = 0; o < 256; o++)
            rd(20'hFFF00 + 20'(o), rom_exp(o), (o >= 'hF0 && o <= 'hF4) ? "R6" : "R7");
        // R2 R8: program RAM read-back.
        for (int a = 0; a < 8192; a++) rd(20'(a), pat(a, 'h3C), "R2");
        // R3 R8: display read-back.
        for (int a = 0; a < 32768; a++) rd(20'hA0000 + 20'(a), pat(a, 'hA5), "R3");
        // R5: boundary probes just outside each window.
        rd(20'h02000, 8'hFF, "R5");
        rd(20'h9FFFF, 8'hFF, "R5");
        rd(20'hA8000, 8'hFF, "R5");
        rd(20'hFFEFF, 8'hFF, "R5");
        rd(20'h50000, 8'hFF, "R5");

        // R8: back-to-back accesses to different regions, one per cycle.
        @(negedge clk); cpu_addr = 20'hFFFF0;
        @(negedge clk); cpu_addr = 20'h00005;
        check("R8 rom then prog", cpu_rdata, 8'hEA);
        @(negedge clk); cpu_addr = 20'hA0009;
        check("R8 prog then disp", cpu_rdata, pat(5, 'h3C));
        @(negedge clk); cpu_addr = 20'h30000;
        check("R8 disp then none", cpu_rdata, pat(9, 'hA5));
        @(negedge clk); cpu_addr = 20'hFFFF2;
        check("R8 none then rom", cpu_rdata, 8'hFF);
        @(negedge clk);
        check("R8 rom IP high", cpu_rdata, 8'h04);
        summary();
    end
endmodule